// File: doc/BRIEF.md
# Skew-Programmable Clock Output Banks

This block is the digital output stage of a clock driver whose outputs can lead or lag a reference phase by whole multiples of a timing unit. It is clocked by a timing-unit clock and keeps a free-running phase counter. Four output banks, each of two identical outputs, are built from that counter. Per bank, two three-level selects choose one of nine settings. On the first two banks the settings are signed skews. On the last two banks the settings are wider skews, with the two end codes used for divided outputs or for an inverted output.

A three-level range select sets how many timing units make one output period. An edge-polarity input chooses whether the outputs align to the rising or the falling edge of the reference phase. A hold input stops the outputs at a parking level. The second bank is exempt from the hold so that it can keep serving as feedback. When the three-level test input is at MID, the hold instead acts on each bank that is set to its lowest code. Stopping and restarting a bank only happens when its waveform enters the parking level, so no short pulse can appear.

Top module: `skew_clock_banks`

## Requirements
- R1: While rst is high, every clkOut bit is 0. The phase counter restarts at count 0 when rst is released.
- R2: Three-level inputs are coded 2'b00 LOW, 2'b01 MID and 2'b10 HIGH. rangeSel LOW, MID and HIGH give a span N of 32, 16 and 8 counts. The counter c runs 0..4N-1 and returns to 0 from any value of 4N-1 or more. After the k-th rising edge following reset release, the outputs show the value for count k-1. With edgePos=1 the zero-skew waveform is high while (c mod N) < N/2.
- R3: Bank b drives clkOut[2b] and clkOut[2b+1] with the same value. Its select field is bankCfg[4b+3:4b], and the upper two bits are the first level. The setting index is 3*first+second, which runs 0..8 from LL to HH. On banks 0 and 1 the skew is s = index-4 timing units, and the output at count c equals the zero-skew waveform at phase (c - s) mod N.
- R4: On bank 2, index 0 gives a divide-by-2 output, high while (c mod 2N) < N. Index 8 gives a divide-by-4 output, high while c < 2N. The other indices give a skew of 2*(index-4).
- R5: On bank 3, index 0 gives the divide-by-2 output and index 8 gives the inverse of the zero-skew waveform. The other indices give a skew of 2*(index-4).
- R6: With edgePos=0 the zero-skew waveform is high while (c mod N) >= N/2, so it falls at phase 0. The divided outputs keep their form from R4 and therefore change on that falling edge.
- R7: With holdOff=1 and testSel not MID, banks 0, 2 and 3 are parked and bank 1 keeps running. Parking is LOW when edgePos=1 and HIGH when edgePos=0 in every mode except inverted.
- R8: A bank 3 set to inverted parks HIGH when edgePos=1 and LOW when edgePos=0.
- R9: With holdOff=1 and testSel MID, exactly the banks whose index is 0 are parked, bank 1 included. The other banks keep their selected waveform.
- R10: A bank's enabled state changes only on a cycle in which its selected waveform moves into the parking level. Until then the bank keeps running or stays parked. After reset every bank is enabled.
- R11: The code 2'b11 acts as MID on rangeSel, testSel and every bank select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing-unit clock |
| rst | input | 1 | Synchronous reset, active high |
| rangeSel | input | 2 | Three-level period span select |
| edgePos | input | 1 | 1: align to the rising edge, 0: align to the falling edge |
| holdOff | input | 1 | Synchronous output hold |
| testSel | input | 2 | Three-level test input; MID makes the hold act per bank |
| bankCfg | input | 16 | Four 4-bit bank selects, two three-level codes each |
| clkOut | output | 8 | Four banks of two clock outputs |

## Verification
The outputs are registered one stage after the phase counter. The first rising edge after reset release therefore shows count 0, and each later edge shows the next count. The bench keeps its own count, updates its model at each rising edge, and compares all eight outputs at the following falling edge. Inputs change only at falling edges, so a new hold or select takes effect at the next rising edge. A park or release then appears only at the first later cycle in which the waveform enters its parking level. The model tracks that pending state, so the checks look for the change at that cycle and not at the moment of the request.

// File: rtl/skew_bank_pkg.sv
package skew_bank_pkg;
  localparam int BANKS = 4;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic [BANKS-1:0] gateNew;
    logic [BANKS-1:0] park;
  } gate_t;

  function automatic logic [1:0] levelOf(input logic [1:0] code);
    return (code == 2'b11) ? 2'b01 : code;
  endfunction

  function automatic logic [3:0] cfgIndex(input logic [3:0] sel);
    logic [1:0] hi;
    logic [1:0] lo;
    hi = levelOf(sel[3:2]);
    lo = levelOf(sel[1:0]);
    return ({2'b00, hi} * 4'd3) + {2'b00, lo};
  endfunction
endpackage

// File: rtl/skew_bank_dp.sv
module skew_bank_dp
  import skew_bank_pkg::*;
#(
  parameter int MAX_SPAN = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             rangeSel,
  input  logic                   edgePos,
  input  logic [BANKS*SEL_W-1:0] bankCfg,
  input  gate_t                  gates,
  output logic [BANKS-1:0]       rawNow,
  output logic [BANKS-1:0]       rawPrev,
  output logic [BANKS-1:0]       bankOut
);
  localparam int CW = $clog2(4 * MAX_SPAN);

  function automatic logic baseAt(input logic [CW-1:0] p, input logic [CW-1:0] h,
                                  input logic pos);
    return pos ? (p < h) : (p >= h);
  endfunction

  logic [CW:0]   span;
  logic [CW:0]   lastIdx;
  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;
  logic [CW-1:0] half;
  logic [CW-1:0] span2;
  logic [CW-1:0] phase;
  logic          div2Raw;
  logic          div4Raw;

  always_comb begin
    unique case (levelOf(rangeSel))
      2'b00:   span = (CW+1)'(MAX_SPAN);
      2'b01:   span = (CW+1)'(MAX_SPAN / 2);
      default: span = (CW+1)'(MAX_SPAN / 4);
    endcase
  end

  assign lastIdx = (span << 2) - 1'b1;
  assign mask    = span[CW-1:0] - 1'b1;
  assign half    = span[CW-1:0] >> 1;
  assign span2   = {span[CW-2:0], 1'b0};
  assign phase   = cnt & mask;
  assign div2Raw = (cnt & (span2 - 1'b1)) < span[CW-1:0];
  assign div4Raw = cnt < span2;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if ({1'b0, cnt} >= lastIdx) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int STEP = (b < 2) ? 1 : 2;
    logic [3:0]    idx;
    logic [CW-1:0] mag;
    logic [CW-1:0] addend;
    logic [CW-1:0] shifted;
    logic          skewRaw;
    logic          bankRaw;

    assign idx = cfgIndex(bankCfg[b*SEL_W +: SEL_W]);

    always_comb begin
      if (idx >= 4'd4) begin
        mag    = CW'(32'(idx - 4'd4) * STEP);
        addend = span[CW-1:0] - mag;
      end else begin
        mag    = CW'(32'(4'd4 - idx) * STEP);
        addend = mag;
      end
      shifted = (phase + addend) & mask;
      skewRaw = baseAt(shifted, half, edgePos);
    end

    if (b < 2) begin : g_plain
      assign bankRaw = skewRaw;
    end else begin : g_ext
      always_comb begin
        if (idx == 4'd0)      bankRaw = div2Raw;
        else if (idx == 4'd8) bankRaw = (b == 2) ? div4Raw : ~baseAt(phase, half, edgePos);
        else                  bankRaw = skewRaw;
      end
    end

    assign rawNow[b] = bankRaw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rawPrev <= '0;
      bankOut <= '0;
    end else begin
      rawPrev <= rawNow;
      bankOut <= (gates.gateNew & rawNow) | (~gates.gateNew & gates.park);
    end
  end

  // R2: once the span has been steady for a cycle the counter stays inside it
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    $stable(rangeSel) |-> ({1'b0, cnt} <= lastIdx));

  // R4: the divide-by-4 waveform moves only at count 0 or at half its period
  p_div4_edge_r4: assert property (@(posedge clk) disable iff (rst)
    ($stable(rangeSel) && !$stable(div4Raw)) |-> (cnt == '0 || cnt == span2));
endmodule

// File: rtl/skew_bank_ctl.sv
module skew_bank_ctl
  import skew_bank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   edgePos,
  input  logic                   holdOff,
  input  logic [1:0]             testSel,
  input  logic [BANKS*SEL_W-1:0] bankCfg,
  input  logic [BANKS-1:0]       rawNow,
  input  logic [BANKS-1:0]       rawPrev,
  input  logic [BANKS-1:0]       bankOut,
  output gate_t                  gates
);
  logic             testMid;
  logic [BANKS-1:0] gateOn;
  logic [BANKS-1:0] park;
  logic [BANKS-1:0] dropReq;
  logic [BANKS-1:0] entering;
  logic [BANKS-1:0] gateNext;

  assign testMid = (levelOf(testSel) == 2'b01);

  for (genvar b = 0; b < BANKS; b++) begin : g_ctl
    localparam bit INV_BANK  = (b == BANKS - 1);
    localparam bit KEEP_BANK = (b == 1);
    logic [3:0] idx;
    assign idx      = cfgIndex(bankCfg[b*SEL_W +: SEL_W]);
    assign park[b]  = ~edgePos ^ (INV_BANK && idx == 4'd8);
    assign dropReq[b] = holdOff & (testMid ? (idx == 4'd0) : !KEEP_BANK);

    // R10: enable state moves only together with an output already at park
    p_gate_at_park_r10: assert property (@(posedge clk) disable iff (rst)
      (gateOn[b] != $past(gateOn[b])) |-> (bankOut[b] == $past(park[b])));

    // R7: a disabled bank shows its parking level
    p_parked_r7: assert property (@(posedge clk) disable iff (rst)
      !gateOn[b] |-> (bankOut[b] == $past(park[b])));
  end

  assign entering = ~(rawNow ^ park) & (rawPrev ^ park);
  assign gateNext = (entering & ~dropReq) | (~entering & gateOn);

  always_ff @(posedge clk) begin
    if (rst) gateOn <= '1;
    else     gateOn <= gateNext;
  end

  assign gates.gateNew = gateNext;
  assign gates.park    = park;

  // R7: outside the per-bank test mode the feedback bank is never stopped
  p_bank1_free_r7: assert property (@(posedge clk) disable iff (rst)
    (!testMid && gateOn[1]) |=> gateOn[1]);
endmodule

// File: rtl/skew_clock_banks.sv
module skew_clock_banks
  import skew_bank_pkg::*;
#(
  parameter int MAX_SPAN = 32,
  parameter int PAIR     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             rangeSel,
  input  logic                   edgePos,
  input  logic                   holdOff,
  input  logic [1:0]             testSel,
  input  logic [BANKS*SEL_W-1:0] bankCfg,
  output logic [BANKS*PAIR-1:0]  clkOut
);
  gate_t            gates;
  logic [BANKS-1:0] rawNow;
  logic [BANKS-1:0] rawPrev;
  logic [BANKS-1:0] bankOut;

  skew_bank_dp #(.MAX_SPAN(MAX_SPAN)) u_dp (
    .clk(clk), .rst(rst), .rangeSel(rangeSel), .edgePos(edgePos),
    .bankCfg(bankCfg), .gates(gates), .rawNow(rawNow), .rawPrev(rawPrev),
    .bankOut(bankOut)
  );

  skew_bank_ctl u_ctl (
    .clk(clk), .rst(rst), .edgePos(edgePos), .holdOff(holdOff),
    .testSel(testSel), .bankCfg(bankCfg), .rawNow(rawNow), .rawPrev(rawPrev),
    .bankOut(bankOut), .gates(gates)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_pair
    for (genvar k = 0; k < PAIR; k++) begin : g_out
      assign clkOut[b*PAIR + k] = bankOut[b];
    end
  end
endmodule

// File: tb/sim_skew_clock_banks.sv
module sim_skew_clock_banks;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  rangeSel = 2'b01;
  logic        edgePos = 1'b1;
  logic        holdOff = 1'b0;
  logic [1:0]  testSel = 2'b00;
  logic [15:0] bankCfg = 16'h5555;
  logic [7:0]  clkOut;

  int  errs = 0;
  int  checks = 0;
  bit  done = 0;
  int  mCnt;
  bit  mPrev [4];
  bit  mGate [4];
  bit  expQ  [4];
  string tagArr [4];

  skew_clock_banks u0 (
    .clk(clk), .rst(rst), .rangeSel(rangeSel), .edgePos(edgePos),
    .holdOff(holdOff), .testSel(testSel), .bankCfg(bankCfg), .clkOut(clkOut)
  );

  always #5 clk = ~clk;

  function automatic int lvl(input logic [1:0] c);
    return (c == 2'b00) ? 0 : (c == 2'b10) ? 2 : 1;
  endfunction

  function automatic int spanOf(input logic [1:0] c);
    int l = lvl(c);
    return (l == 0) ? 32 : (l == 1) ? 16 : 8;
  endfunction

  function automatic int idxOf(input logic [3:0] f);
    return 3 * lvl(f[3:2]) + lvl(f[1:0]);
  endfunction

  function automatic logic [1:0] codeOf(input int l);
    return (l == 0) ? 2'b00 : (l == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [3:0] fieldOf(input int idx);
    return {codeOf(idx / 3), codeOf(idx % 3)};
  endfunction

  function automatic bit baseAt(input int p, input int span, input bit pe);
    return pe ? (p < span / 2) : (p >= span / 2);
  endfunction

  function automatic bit expRaw(input int b, input int idx, input int c, input int span,
                                input bit pe);
    int ph = c % span;
    int s;
    int p;
    if (b >= 2 && idx == 0) return (c % (2 * span)) < span;
    if (b == 2 && idx == 8) return c < 2 * span;
    if (b == 3 && idx == 8) return !baseAt(ph, span, pe);
    s = (b < 2) ? idx - 4 : 2 * (idx - 4);
    p = (((ph - s) % span) + span) % span;
    return baseAt(p, span, pe);
  endfunction

  task automatic check(input bit act, input bit exp, input string tag, input int pin);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: clkOut[%0d] got %0b expected %0b", tag, pin, act, exp);
    end
  endtask

  task automatic resetRun;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (clkOut !== 8'h00) begin
      errs++;
      $display("FAIL R1: clkOut got %0h expected 00", clkOut);
    end
    mCnt = 0;
    for (int b = 0; b < 4; b++) begin
      mPrev[b] = 1'b0;
      mGate[b] = 1'b1;
    end
    rst = 1'b0;
  endtask

  task automatic stepCheck(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      begin
        int  span = spanOf(rangeSel);
        bit  tMid = (lvl(testSel) == 1);
        for (int b = 0; b < 4; b++) begin
          int idx = idxOf(bankCfg[b*4 +: 4]);
          bit raw = expRaw(b, idx, mCnt, span, edgePos);
          bit park = !edgePos ^ (b == 3 && idx == 8);
          bit drop = holdOff && (tMid ? (idx == 0) : (b != 1));
          bit enter = (raw == park) && (mPrev[b] != park);
          bit gn = enter ? !drop : mGate[b];
          if (mGate[b] != !drop)                  tagArr[b] = "R10";
          else if (drop && b == 3 && idx == 8)   tagArr[b] = "R8";
          else if (holdOff && tMid)              tagArr[b] = "R9";
          else if (holdOff)                      tagArr[b] = "R7";
          else if (bankCfg[b*4 +: 2] == 2'b11 || bankCfg[b*4+2 +: 2] == 2'b11 ||
                   rangeSel == 2'b11)            tagArr[b] = "R11";
          else if (!edgePos)                     tagArr[b] = "R6";
          else if (b == 0 && idx == 4)           tagArr[b] = "R2";
          else if (b < 2)                        tagArr[b] = "R3";
          else if (b == 2)                       tagArr[b] = "R4";
          else                                   tagArr[b] = "R5";
          expQ[b]  = gn ? raw : park;
          mGate[b] = gn;
          mPrev[b] = raw;
        end
        mCnt = (mCnt >= 4 * span - 1) ? 0 : mCnt + 1;
      end
      @(negedge clk);
      for (int b = 0; b < 4; b++)
        for (int k = 0; k < 2; k++)
          check(clkOut[2*b + k], expQ[b], tagArr[b], 2*b + k);
    end
  endtask

  task automatic gateRun(input bit pe, input logic [1:0] ts, input int i0, input int i1,
                         input int i2, input int i3, input int lead);
    rangeSel = 2'b01;
    edgePos  = pe;
    testSel  = ts;
    holdOff  = 1'b0;
    bankCfg  = {fieldOf(i3), fieldOf(i2), fieldOf(i1), fieldOf(i0)};
    resetRun();
    stepCheck(lead);
    holdOff = 1'b1;
    stepCheck(70);
    holdOff = 1'b0;
    stepCheck(70);
  endtask

  initial begin
    // sweeps over span, polarity and every select index (R2..R6, R11)
    for (int r = 0; r < 4; r++)
      for (int pe = 0; pe < 2; pe++)
        for (int i = 0; i < 10; i++)
          for (int mix = 0; mix < 2; mix++) begin
            rangeSel = r[1:0];
            edgePos  = pe[0];
            holdOff  = 1'b0;
            testSel  = 2'b00;
            for (int b = 0; b < 4; b++)
              bankCfg[b*4 +: 4] = (i == 9) ? ((mix == 1 && b[0]) ? 4'b0111 : 4'b1111)
                                 : fieldOf(mix == 1 ? (i + 2 * b) % 9 : i);
            resetRun();
            stepCheck(4 * spanOf(rangeSel) + 3);
          end
    // hold with test input LOW and HIGH (R7, R8, R10)
    gateRun(1'b1, 2'b00, 1, 6, 4, 8, 37);
    gateRun(1'b0, 2'b00, 1, 6, 4, 8, 41);
    gateRun(1'b1, 2'b10, 3, 4, 0, 2, 45);
    gateRun(1'b0, 2'b00, 7, 2, 8, 0, 30);
    // per-bank disable in test MID mode (R9), including the alias code
    gateRun(1'b1, 2'b01, 0, 0, 4, 1, 37);
    gateRun(1'b0, 2'b11, 4, 0, 0, 8, 43);
    gateRun(1'b1, 2'b01, 5, 3, 0, 0, 39);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule